// File: doc/BRIEF.md
# Flash Bus Write Qualifier

This block sits between the pins of a parallel flash bus and the command register of the flash. Its job is to decide whether a host bus cycle counts as a real write. Every clock it samples the active-low chip enable, output enable and write enable strobes. Each strobe passes through a filter that ignores short noise pulses. A write is accepted only when the strobes are in the write combination, the supply is not in lockout, and the qualifier has been armed since the last power-on or lockout. An accepted write produces a single-cycle strobe that carries the captured address and data.

Protection is checked on each accepted cycle. If the cycle is marked as a program or erase commit and its address falls in a protected sector group, the strobe is replaced by a one-cycle reject pulse. A group counts as protected when its stored protection bit is set. An actively driven low write-protect pin also forces protection of one boundary group, either the first or the last, whatever that group's stored bit says.

While the supply is in lockout, the block asks the downstream logic to return to read mode. The same request is held throughout reset.

Top module: `flash_wr_gate`

## Requirements
- R1: A write is accepted only on the filtered rising edge of `we_n` while filtered `ce_n` is low and filtered `oe_n` is high. It produces exactly one cycle of `wr_stb`. If `oe_n` is low or `ce_n` is high, no strobe is produced.
- R2: A level change on any strobe is recognised only after `FILT` consecutive clock samples at the new level. A `we_n` low pulse lasting `FILT-1` samples produces no strobe, while a pulse lasting `FILT` samples does produce one.
- R3: While `lockout` is high, no write or reject pulse is produced. `rd_mode_req` is high in the cycle after `lockout` is sampled high and falls in the cycle after `lockout` is sampled low.
- R4: During reset, `wr_stb` and `rej_stb` are low and `rd_mode_req` is high.
- R5: After reset, or after `lockout` clears, the qualifier is armed only once filtered `ce_n` or `we_n` has been seen high. If both are held low through power-up or lockout, the first `we_n` rise that follows is not accepted.
- R6: When `wp_drv` is 1 and `wp_n` is 0, a program/erase cycle (`pe_cyc`=1) to the boundary group is rejected with `rej_stb` and gives no `wr_stb`. The boundary group is group 0 when `BOUND_TOP`=0 and group `NGRP-1` otherwise. This holds regardless of that group's `grp_locked` bit.
- R7: With the pin protection inactive, a program/erase cycle is rejected exactly when `grp_locked[g]` is 1. The group index g is `addr[AW-1:GRP_BITS]`.
- R8: When `wp_drv` is 0, the write-protect pin behaves as high, whatever the value of `wp_n`.
- R9: A cycle with `pe_cyc`=0 is never rejected, whatever the protection state.
- R10: Address, data and `pe_cyc` are captured in the cycle where filtered `ce_n` and `we_n` first become low together. `wr_addr` and `wr_data` show the captured values while `wr_stb` is high, even if `addr` changes before `we_n` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Power-on reset, active low |
| ce_n | input | 1 | Chip enable strobe, active low |
| oe_n | input | 1 | Output enable strobe, active low |
| we_n | input | 1 | Write enable strobe, active low |
| wp_n | input | 1 | Write-protect pin level |
| wp_drv | input | 1 | 1 when the write-protect pin is driven; 0 models the floating, pulled-up pin |
| lockout | input | 1 | Low-supply lockout flag |
| addr | input | AW | Bus address |
| data | input | DW | Bus data |
| pe_cyc | input | 1 | Cycle is a program or erase commit |
| grp_locked | input | NGRP | Stored protection bit per sector group |
| wr_stb | output | 1 | One-cycle accepted write strobe |
| wr_addr | output | AW | Captured address |
| wr_data | output | DW | Captured data |
| rej_stb | output | 1 | One-cycle protection reject pulse |
| rd_mode_req | output | 1 | Request to return to read mode |

## Verification
The assertions treat every input as already synchronous to `clk`. They also assume that `lockout` is low as reset is released, so that a strobe is never traced back to a lockout sample taken before reset. Address, data and `pe_cyc` are taken to stay steady from the moment both strobes are low until `we_n` is recognised high. The bench changes every input only on the falling clock edge and holds `lockout` low around reset. Except in the deliberate glitch and late-address tests, it keeps each strobe level for more than `FILT` samples.

// File: rtl/fwg_pkg.sv
package fwg_pkg;

   // strobe lane indices
   localparam int NSTB   = 3;
   localparam int STB_CE = 0;
   localparam int STB_OE = 1;
   localparam int STB_WE = 2;

   // level each filtered strobe takes in reset: chip and write enable
   // start asserted so that a bus held active through power-up is never
   // mistaken for an idle bus
   function automatic bit stb_rst_lvl(input int lane);
      return (lane == STB_OE);
   endfunction

   // width of a run counter that must reach n-1
   function automatic int run_width(input int n);
      return (n > 2) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/fwg_glitch_filt.sv
module fwg_glitch_filt #(
   parameter int FILT    = 3,
   parameter bit RST_LVL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic raw,
   output logic lvl
);
   localparam int CW = fwg_pkg::run_width(FILT);
   localparam logic [CW-1:0] LAST = CW'(FILT - 1);

   logic [CW-1:0] run;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lvl <= RST_LVL;
         run <= '0;
      end else if (raw == lvl) begin
         run <= '0;
      end else if (run == LAST) begin
         lvl <= raw;
         run <= '0;
      end else begin
         run <= run + 1'b1;
      end
   end

   // R2
   lvl_follows_raw_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lvl != $past(lvl)) |-> ($past(raw) == lvl));

endmodule

// File: rtl/fwg_arm.sv
module fwg_arm (
   input  logic clk,
   input  logic rst_n,
   input  logic lockout,
   input  logic ce_f,
   input  logic we_f,
   output logic armed
);
   always_ff @(posedge clk) begin
      if (!rst_n)
         armed <= 1'b0;
      else if (lockout)
         armed <= 1'b0;
      else if (ce_f || we_f)
         armed <= 1'b1;
   end

   // R5
   lockout_disarms_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lockout |=> !armed);

endmodule

// File: rtl/fwg_prot.sv
module fwg_prot #(
   parameter int GIW       = 6,
   parameter int NGRP      = 64,
   parameter bit BOUND_TOP = 1'b0
) (
   input  logic [GIW-1:0]  grp_idx,
   input  logic [NGRP-1:0] locked,
   input  logic            wp_low,
   output logic            prot,
   output logic            stored_hit
);
   localparam int BND = BOUND_TOP ? (NGRP - 1) : 0;

   logic [NGRP-1:0] hit;
   logic [NGRP-1:0] forced;

   for (genvar g = 0; g < NGRP; g++) begin : g_grp
      assign hit[g]    = (grp_idx == GIW'(g));
      assign forced[g] = wp_low && (g == BND);
   end

   assign stored_hit = |(hit & locked);
   assign prot       = |(hit & (locked | forced));

endmodule

// File: rtl/flash_wr_gate.sv
module flash_wr_gate #(
   parameter int AW        = 24,
   parameter int DW        = 16,
   parameter int GRP_BITS  = 18,
   parameter int NGRP      = 64,
   parameter int FILT      = 3,
   parameter bit BOUND_TOP = 1'b0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            ce_n,
   input  logic            oe_n,
   input  logic            we_n,
   input  logic            wp_n,
   input  logic            wp_drv,
   input  logic            lockout,
   input  logic [AW-1:0]   addr,
   input  logic [DW-1:0]   data,
   input  logic            pe_cyc,
   input  logic [NGRP-1:0] grp_locked,
   output logic            wr_stb,
   output logic [AW-1:0]   wr_addr,
   output logic [DW-1:0]   wr_data,
   output logic            rej_stb,
   output logic            rd_mode_req
);
   import fwg_pkg::*;

   localparam int GIW = AW - GRP_BITS;

   // elaboration checks
   if (FILT < 1) begin : g_bad_filt
      $error("FILT must be at least 1");
   end
   if (GRP_BITS < 1 || GIW < 1) begin : g_bad_split
      $error("GRP_BITS must leave at least one group index bit in AW");
   end
   if (GIW >= 1 && GIW < 31 && NGRP > (1 << GIW)) begin : g_bad_ngrp
      $error("NGRP exceeds the groups addressable by the upper address bits");
   end
   if (NGRP < 1 || DW < 1) begin : g_bad_size
      $error("NGRP and DW must be positive");
   end

   // strobe filtering
   logic [NSTB-1:0] raw_v;
   logic [NSTB-1:0] filt_v;

   assign raw_v[STB_CE] = ce_n;
   assign raw_v[STB_OE] = oe_n;
   assign raw_v[STB_WE] = we_n;

   for (genvar i = 0; i < NSTB; i++) begin : g_filt
      fwg_glitch_filt #(
         .FILT    (FILT),
         .RST_LVL (stb_rst_lvl(i))
      ) i_filt (
         .clk   (clk),
         .rst_n (rst_n),
         .raw   (raw_v[i]),
         .lvl   (filt_v[i])
      );
   end

   logic ce_f, oe_f, we_f;
   assign ce_f = filt_v[STB_CE];
   assign oe_f = filt_v[STB_OE];
   assign we_f = filt_v[STB_WE];

   // arming after reset and lockout
   logic armed;

   fwg_arm i_arm (
      .clk     (clk),
      .rst_n   (rst_n),
      .lockout (lockout),
      .ce_f    (ce_f),
      .we_f    (we_f),
      .armed   (armed)
   );

   // edge tracking and capture
   logic we_q;
   logic both_low_q;
   logic both_low;
   logic [AW-1:0] a_hold;
   logic [DW-1:0] d_hold;
   logic pe_hold;

   assign both_low = !ce_f && !we_f;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         we_q       <= 1'b0;
         both_low_q <= 1'b1;
         a_hold     <= '0;
         d_hold     <= '0;
         pe_hold    <= 1'b0;
      end else begin
         we_q       <= we_f;
         both_low_q <= both_low;
         if (both_low && !both_low_q) begin
            a_hold  <= addr;
            d_hold  <= data;
            pe_hold <= pe_cyc;
         end
      end
   end

   // protection lookup
   logic wp_low;
   logic prot;
   logic stored_hit;
   logic [GIW-1:0] grp_idx;

   assign wp_low  = wp_drv && !wp_n;
   assign grp_idx = a_hold[AW-1:GRP_BITS];

   fwg_prot #(
      .GIW       (GIW),
      .NGRP      (NGRP),
      .BOUND_TOP (BOUND_TOP)
   ) i_prot (
      .grp_idx    (grp_idx),
      .locked     (grp_locked),
      .wp_low     (wp_low),
      .prot       (prot),
      .stored_hit (stored_hit)
   );

   // qualification and outputs
   logic accept;
   logic deny;

   assign accept = we_f && !we_q && !ce_f && oe_f && armed && !lockout;
   assign deny   = pe_hold && prot;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_stb      <= 1'b0;
         rej_stb     <= 1'b0;
         rd_mode_req <= 1'b1;
      end else begin
         wr_stb      <= accept && !deny;
         rej_stb     <= accept && deny;
         rd_mode_req <= lockout;
      end
   end

   assign wr_addr = a_hold;
   assign wr_data = d_hold;

   // R1
   single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stb |=> !wr_stb);

   // R1
   strobe_combo_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stb |-> $past(!ce_f && oe_f && we_f));

   // R3
   no_write_in_lockout_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stb || rej_stb) |-> !$past(lockout));

   // R3
   read_mode_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lockout |=> rd_mode_req);

   // R5
   armed_before_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stb |-> $past(armed));

   // R6
   strobe_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_stb && rej_stb));

   // R7
   stored_lock_honoured_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stb |-> !($past(pe_hold) && $past(stored_hit)));

endmodule

// File: tb/test_flash_wr_gate.sv
`timescale 1ns/1ps
module test_flash_wr_gate;

   localparam int AW   = 6;
   localparam int DW   = 8;
   localparam int GB   = 3;
   localparam int NG   = 8;
   localparam int FILT = 3;
   localparam int H    = FILT + 2;
   localparam int BND  = 0;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
   logic wp_n = 1'b1, wp_drv = 1'b1, lockout = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] data = '0;
   logic pe_cyc = 1'b0;
   logic [NG-1:0] grp_locked = '0;
   logic wr_stb, rej_stb, rd_mode_req;
   logic [AW-1:0] wr_addr;
   logic [DW-1:0] wr_data;

   int total = 0;
   int bad = 0;
   int nwr = 0;
   int nrej = 0;
   logic [AW-1:0] last_a = '0;
   logic [DW-1:0] last_d = '0;

   always #4 clk = ~clk;

   flash_wr_gate #(
      .AW(AW), .DW(DW), .GRP_BITS(GB), .NGRP(NG), .FILT(FILT), .BOUND_TOP(1'b0)
   ) i_flash_wr_gate (
      .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
      .wp_n(wp_n), .wp_drv(wp_drv), .lockout(lockout), .addr(addr),
      .data(data), .pe_cyc(pe_cyc), .grp_locked(grp_locked),
      .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
      .rej_stb(rej_stb), .rd_mode_req(rd_mode_req)
   );

   always @(negedge clk) begin
      if (wr_stb) begin
         nwr++;
         last_a = wr_addr;
         last_d = wr_data;
      end
      if (rej_stb) nrej++;
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   // full bus write; oe and ce levels are selectable for inhibit cases
   task automatic bus_wr(input logic [AW-1:0] a, input logic [DW-1:0] d,
                         input logic pe, input logic oe_lvl, input logic ce_lvl);
      @(negedge clk);
      ce_n = ce_lvl; oe_n = oe_lvl; addr = a; data = d; pe_cyc = pe;
      idle(H); we_n = 1'b0;
      idle(H); we_n = 1'b1;
      idle(H); ce_n = 1'b1; oe_n = 1'b1;
      idle(H);
   endtask

   task automatic expect_wr(input logic [AW-1:0] a, input logic [DW-1:0] d,
                            input logic pe, input int ew, input int er,
                            input string req);
      int w0, r0;
      w0 = nwr; r0 = nrej;
      bus_wr(a, d, pe, 1'b1, 1'b0);
      chk(nwr - w0 == ew, req, "write strobes", nwr - w0, ew);
      chk(nrej - r0 == er, req, "reject pulses", nrej - r0, er);
      if (ew == 1) begin
         chk(last_a == a, req, "captured address", int'(last_a), int'(a));
         chk(last_d == d, req, "captured data", int'(last_d), int'(d));
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      bad++;
      total++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      int w0, r0;
      // R5 power-up with the bus held in write combination
      ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b1;
      idle(3);
      // R4 reset state
      chk(wr_stb == 1'b0, "R4", "wr_stb in reset", int'(wr_stb), 0);
      chk(rej_stb == 1'b0, "R4", "rej_stb in reset", int'(rej_stb), 0);
      chk(rd_mode_req == 1'b1, "R4", "rd_mode_req in reset", int'(rd_mode_req), 1);
      rst_n = 1'b1;
      idle(H);
      chk(rd_mode_req == 1'b0, "R3", "rd_mode_req after reset", int'(rd_mode_req), 0);
      w0 = nwr;
      we_n = 1'b1;
      idle(H);
      chk(nwr == w0, "R5", "first rise after power-up", nwr - w0, 0);
      // bus now armed: a second cycle with ce still low goes through
      addr = 6'd9; data = 8'h5A; pe_cyc = 1'b0;
      we_n = 1'b0; idle(H); we_n = 1'b1; idle(H);
      chk(nwr == w0 + 1, "R5", "write once armed", nwr - w0, 1);
      chk(last_a == 6'd9, "R10", "address once armed", int'(last_a), 9);
      ce_n = 1'b1;
      idle(H);

      // R1 basic write and inhibit combinations
      expect_wr(6'd3, 8'hC3, 1'b0, 1, 0, "R1");
      w0 = nwr;
      bus_wr(6'd4, 8'h11, 1'b0, 1'b0, 1'b0);
      chk(nwr == w0, "R1", "oe low inhibits", nwr - w0, 0);
      bus_wr(6'd4, 8'h12, 1'b0, 1'b1, 1'b1);
      chk(nwr == w0, "R1", "ce high inhibits", nwr - w0, 0);

      // R2 glitch filter boundary
      for (int len = FILT - 1; len <= FILT; len++) begin
         w0 = nwr;
         @(negedge clk);
         ce_n = 1'b0; addr = 6'(len); data = 8'(len + 64); pe_cyc = 1'b0;
         idle(H); we_n = 1'b0;
         idle(len); we_n = 1'b1;
         idle(H); ce_n = 1'b1;
         idle(H);
         chk(nwr - w0 == ((len >= FILT) ? 1 : 0), "R2", "we pulse length",
             nwr - w0, (len >= FILT) ? 1 : 0);
      end

      // R10 address changing after capture
      @(negedge clk);
      ce_n = 1'b0; addr = 6'd21; data = 8'h77;
      idle(H); we_n = 1'b0;
      idle(H); addr = 6'd42; data = 8'h88;
      idle(2); we_n = 1'b1;
      idle(H); ce_n = 1'b1;
      idle(H);
      chk(last_a == 6'd21, "R10", "address held from capture", int'(last_a), 21);
      chk(last_d == 8'h77, "R10", "data held from capture", int'(last_d), 'h77);

      // R3 lockout ignores writes and requests read mode
      @(negedge clk); lockout = 1'b1;
      idle(2);
      chk(rd_mode_req == 1'b1, "R3", "rd_mode_req in lockout", int'(rd_mode_req), 1);
      w0 = nwr; r0 = nrej;
      bus_wr(6'd5, 8'h05, 1'b0, 1'b1, 1'b0);
      bus_wr(6'd0, 8'h06, 1'b1, 1'b1, 1'b0);
      chk(nwr == w0 && nrej == r0, "R3", "strobes during lockout",
          nwr - w0 + nrej - r0, 0);
      // R5 lockout clears with both strobes low
      ce_n = 1'b0; we_n = 1'b0;
      idle(H); lockout = 1'b0;
      idle(2);
      chk(rd_mode_req == 1'b0, "R3", "rd_mode_req after lockout", int'(rd_mode_req), 0);
      idle(H); we_n = 1'b1;
      idle(H); ce_n = 1'b1;
      idle(H);
      chk(nwr == w0, "R5", "first rise after lockout", nwr - w0, 0);
      expect_wr(6'd13, 8'h31, 1'b0, 1, 0, "R5");

      // R6 R7 R8 R9 sweep over pin mode, stored bits, group and cycle type
      for (int wpm = 0; wpm < 3; wpm++) begin
         wp_drv = (wpm != 2);
         wp_n   = (wpm == 1);
         for (int pat = 0; pat < 2; pat++) begin
            grp_locked = (pat == 0) ? 8'b1010_0101 : 8'b0101_1010;
            for (int g = 0; g < NG; g++) begin
               for (int pe = 0; pe < 2; pe++) begin
                  bit pr;
                  int er;
                  string req;
                  pr  = grp_locked[g] || (wpm == 0 && g == BND);
                  er  = (pe == 1 && pr) ? 1 : 0;
                  if (pe == 0) req = "R9";
                  else if (wpm == 0 && g == BND) req = "R6";
                  else if (wpm == 2) req = "R8";
                  else req = "R7";
                  expect_wr({3'(g), 3'(g + wpm)}, 8'(g * 16 + pe * 4 + wpm),
                            1'(pe), 1 - er, er, req);
               end
            end
         end
      end

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule